// File: doc/BRIEF.md
# Soft-Start Step Sequencer

This block times the start-up phase of a flyback power controller once the supply has crossed its turn-on level. A request input starts a fixed timed sequence. First a precharge current source is enabled for a short burst. A current-sink DAC code then steps down from its full value toward zero, one step per interval, so the regulation node climbs in equal increments. When the precharge burst ends, an arm signal for the burst-mode comparator goes high and stays high. After the last step the sink is switched off and a completion flag is raised.

All intervals are given in microseconds. A parameter states the number of clock cycles in one microsecond, so each interval is an exact cycle count. An undervoltage reset input clears every output back to the idle state on the next clock edge. The sequence can then be started again. The analog DAC, resistor and capacitor are outside the block.

Top module: `soft_start_seq`

## Requirements
- R1: After reset and before any start, every output is low and the sink code is 0.
- R2: A start request seen while idle makes precharge enable high, sink enable high, the sink code equal to NUM_STEPS (8 by default) and arm low on the next cycle.
- R3: Precharge enable stays high for exactly PRECHARGE_US*CYC_PER_US cycles and then stays low.
- R4: Arm rises in the cycle in which precharge falls. It is never high together with precharge, and it stays high through completion until an undervoltage reset.
- R5: While the sequence runs, the sink code drops by exactly one every STEP_US*CYC_PER_US cycles after the start, and it never rises.
- R6: NUM_STEPS intervals after the start (24 ms by default), the code reaches 0. In that same cycle sink enable falls and the done flag rises.
- R7: The done flag is sticky and the code stays saturated at 0. A start request while running or done has no effect on any output.
- R8: A high undervoltage reset returns all outputs to the R1 state on the next cycle. It wins over a start request in the same cycle.
- R9: After an undervoltage reset, a new start runs the full sequence from the beginning with fresh timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Synchronous power-on request |
| uv_rst_i | input | 1 | Synchronous undervoltage reset |
| precharge_en_o | output | 1 | Precharge current source enable |
| sink_code_o | output | $clog2(NUM_STEPS+1) | Current-sink DAC code |
| sink_en_o | output | 1 | Current sink enable |
| burst_arm_o | output | 1 | Burst-mode comparator arm |
| ss_done_o | output | 1 | Soft-start complete, sticky |

## Verification
The bench samples the cycles on both sides of every timing edge: the last cycle of precharge, each code step, and the final step. An off-by-one timer therefore shows up as a wrong code or a wrong enable one cycle early or late. It pulses start in the middle of a run and after completion, which catches a design that reloads the code or drops the done flag. It asserts undervoltage reset together with start, which catches a design that lets the start win. It also resets in the middle of the precharge burst and then starts again. A precharge timer that is not cleared would then shorten the next burst, and the bench would see precharge fall early.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

   typedef enum logic [1:0] {
      SS_IDLE = 2'd0,
      SS_RUN  = 2'd1,
      SS_DONE = 2'd2
   } ss_state_t;

endpackage

// File: rtl/ssq_interval_timer.sv
module ssq_interval_timer #(
   parameter int LIMIT = 16,
   localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clear,
   output logic tick
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (run) begin
         cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   assign tick = run && !clear && (cnt == LAST);

endmodule

// File: rtl/ssq_code_stepper.sv
module ssq_code_stepper #(
   parameter int NUM_STEPS = 8,
   localparam int CODE_W = $clog2(NUM_STEPS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              clear,
   input  logic              step,
   output logic [CODE_W-1:0] code,
   output logic              at_last
);
   localparam logic [CODE_W-1:0] FULL = CODE_W'(NUM_STEPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
      end else if (clear) begin
         code <= '0;
      end else if (load) begin
         code <= FULL;
      end else if (step && (code != '0)) begin
         code <= code - 1'b1;
      end
   end

   assign at_last = (code == CODE_W'(1));

endmodule

// File: rtl/soft_start_seq.sv
module soft_start_seq
   import ssq_pkg::*;
#(
   parameter int CYC_PER_US   = 100,
   parameter int PRECHARGE_US = 12,
   parameter int STEP_US      = 3000,
   parameter int NUM_STEPS    = 8,
   localparam int CODE_W = $clog2(NUM_STEPS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              uv_rst_i,
   output logic              precharge_en_o,
   output logic [CODE_W-1:0] sink_code_o,
   output logic              sink_en_o,
   output logic              burst_arm_o,
   output logic              ss_done_o
);
   localparam int PRE_CYC  = PRECHARGE_US * CYC_PER_US;
   localparam int STEP_CYC = STEP_US * CYC_PER_US;

   generate
      if (CYC_PER_US < 1) begin : g_bad_clk
         $error("CYC_PER_US must be at least 1");
      end
      if (NUM_STEPS < 1) begin : g_bad_steps
         $error("NUM_STEPS must be at least 1");
      end
      if (PRE_CYC < 2) begin : g_bad_pre
         $error("precharge window must span at least 2 cycles");
      end
      if (PRE_CYC >= STEP_CYC) begin : g_bad_order
         $error("precharge window must end before the first step");
      end
   endgenerate

   ss_state_t state_q, state_d;
   logic      pre_q, arm_q;
   logic      start_ok, pre_tick, step_tick, at_last;

   assign start_ok = (state_q == SS_IDLE) && start_i && !uv_rst_i;

   always_comb begin
      state_d = state_q;
      if (uv_rst_i) begin
         state_d = SS_IDLE;
      end else begin
         unique case (state_q)
            SS_IDLE: if (start_i)              state_d = SS_RUN;
            SS_RUN:  if (step_tick && at_last) state_d = SS_DONE;
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SS_IDLE;
         pre_q   <= 1'b0;
         arm_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (uv_rst_i) begin
            pre_q <= 1'b0;
            arm_q <= 1'b0;
         end else begin
            if (start_ok)      pre_q <= 1'b1;
            else if (pre_tick) pre_q <= 1'b0;
            if (pre_tick)      arm_q <= 1'b1;
         end
      end
   end

   ssq_interval_timer #(.LIMIT(PRE_CYC)) u_pre_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (pre_q),
      .clear (uv_rst_i || !pre_q),
      .tick  (pre_tick)
   );

   ssq_interval_timer #(.LIMIT(STEP_CYC)) u_step_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state_q == SS_RUN),
      .clear (uv_rst_i || (state_q != SS_RUN)),
      .tick  (step_tick)
   );

   ssq_code_stepper #(.NUM_STEPS(NUM_STEPS)) u_stepper (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (start_ok),
      .clear   (uv_rst_i),
      .step    (step_tick),
      .code    (sink_code_o),
      .at_last (at_last)
   );

   assign precharge_en_o = pre_q;
   assign burst_arm_o    = arm_q;
   assign sink_en_o      = (state_q == SS_RUN);
   assign ss_done_o      = (state_q == SS_DONE);

endmodule

// File: rtl/ssq_checker.sv
module ssq_checker #(
   parameter int CYC_PER_US   = 100,
   parameter int PRECHARGE_US = 12,
   parameter int NUM_STEPS    = 8,
   localparam int CW = $clog2(NUM_STEPS + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          uv_rst_i,
   input logic          precharge_en_o,
   input logic          sink_en_o,
   input logic          burst_arm_o,
   input logic          ss_done_o,
   input logic [CW-1:0] sink_code_o
);
   localparam int PRE_CYC = PRECHARGE_US * CYC_PER_US;

   int pre_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pre_cnt <= 0;
      else if (precharge_en_o) pre_cnt <= pre_cnt + 1;
      else                     pre_cnt <= 0;
   end

   p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sink_en_o) |-> (sink_code_o == CW'(NUM_STEPS) && precharge_en_o && !burst_arm_o));

   p_pre_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
      precharge_en_o |-> (pre_cnt < PRE_CYC));

   p_arm_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(precharge_en_o && burst_arm_o));

   p_code_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sink_en_o |=> (sink_code_o <= $past(sink_code_o)));

   p_done_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ss_done_o |-> (!sink_en_o && sink_code_o == '0 && burst_arm_o));

   p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_done_o && !uv_rst_i) |=> ss_done_o);

   p_uv_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      uv_rst_i |=> (!precharge_en_o && !sink_en_o && !burst_arm_o && !ss_done_o && sink_code_o == '0));

endmodule

bind soft_start_seq ssq_checker #(
   .CYC_PER_US   (CYC_PER_US),
   .PRECHARGE_US (PRECHARGE_US),
   .NUM_STEPS    (NUM_STEPS)
) u_ssq_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .uv_rst_i       (uv_rst_i),
   .precharge_en_o (precharge_en_o),
   .sink_en_o      (sink_en_o),
   .burst_arm_o    (burst_arm_o),
   .ss_done_o      (ss_done_o),
   .sink_code_o    (sink_code_o)
);

// File: tb/soft_start_seq_tb.sv
`timescale 1ns/1ps
module soft_start_seq_tb;
   localparam int CPU  = 2;
   localparam int PUS  = 12;
   localparam int SUS  = 3000;
   localparam int NS   = 8;
   localparam int PRE  = PUS * CPU;
   localparam int STEP = SUS * CPU;
   localparam int CW   = $clog2(NS + 1);
   localparam int VW   = CW + 4;

   typedef struct {
      int             at;
      logic [VW-1:0]  v;
      string          tag;
   } exp_t;

   exp_t q[$];

   logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, uv_rst_i = 1'b0;
   logic precharge_en_o, sink_en_o, burst_arm_o, ss_done_o;
   logic [CW-1:0] sink_code_o;

   int cyc = 0, checks = 0, failures = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   soft_start_seq #(
      .CYC_PER_US(CPU), .PRECHARGE_US(PUS), .STEP_US(SUS), .NUM_STEPS(NS)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .uv_rst_i(uv_rst_i),
      .precharge_en_o(precharge_en_o), .sink_code_o(sink_code_o),
      .sink_en_o(sink_en_o), .burst_arm_o(burst_arm_o), .ss_done_o(ss_done_o)
   );

   // vector layout: {precharge, sink_en, arm, done, code}
   function automatic logic [VW-1:0] mk(logic p, logic e, logic a, logic d, int c);
      return {p, e, a, d, CW'(c)};
   endfunction

   task automatic push(int at, logic [VW-1:0] v, string tag);
      exp_t it;
      it.at = at; it.v = v; it.tag = tag;
      q.push_back(it);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      while (q.size() > 0 && q[0].at <= cyc) begin
         exp_t it;
         logic [VW-1:0] got;
         it  = q.pop_front();
         got = {precharge_en_o, sink_en_o, burst_arm_o, ss_done_o, sink_code_o};
         checks++;
         if (it.at != cyc || got !== it.v) begin
            failures++;
            $display("FAIL %s cyc=%0d actual=%b expected=%b", it.tag, cyc, got, it.v);
         end
      end
   end

   task automatic wait_until(int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic drain();
      while (q.size() > 0) @(negedge clk);
      @(negedge clk);
   endtask

   // start pulse; expected items for the start cycle pushed first
   task automatic do_start(output int s, input string tag);
      @(negedge clk);
      s = cyc + 1;
      push(s, mk(1, 1, 0, 0, NS), tag);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic run_full(bit poke_mid, string pfx);
      int s;
      @(negedge clk);
      s = cyc + 1;
      push(s,           mk(1, 1, 0, 0, NS), {pfx, " R2"});
      push(s + PRE - 1, mk(1, 1, 0, 0, NS), {pfx, " R3"});
      push(s + PRE,     mk(0, 1, 1, 0, NS), {pfx, " R3 R4"});
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (poke_mid) begin
         wait_until(s + 100);
         start_i = 1'b1;
         push(s + 102, mk(0, 1, 1, 0, NS), "R7 start while running");
         @(negedge clk);
         start_i = 1'b0;
      end
      for (int k = 1; k <= NS; k++) begin
         push(s + k*STEP - 1, mk(0, 1, 1, 0, NS - k + 1), {pfx, " R5 before step"});
         push(s + k*STEP, mk(0, k < NS, 1, k == NS, NS - k),
              (k == NS) ? {pfx, " R6 final"} : {pfx, " R5 step"});
      end
      drain();
   endtask

   initial begin
      int s, t;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      push(cyc + 2, mk(0, 0, 0, 0, 0), "R1 idle");
      drain();

      run_full(1'b1, "A");

      // sticky done, saturation, start ignored once done
      @(negedge clk);
      t = cyc;
      push(t + 2,   mk(0, 0, 1, 1, 0), "R7 start after done");
      push(t + 500, mk(0, 0, 1, 1, 0), "R7 sticky");
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      drain();

      // undervoltage reset from done
      @(negedge clk);
      push(cyc + 1, mk(0, 0, 0, 0, 0), "R8 clear from done");
      uv_rst_i = 1'b1;
      @(negedge clk);
      uv_rst_i = 1'b0;
      drain();

      // reset together with start mid-run
      do_start(s, "R2 run B");
      wait_until(s + STEP + 5);
      push(cyc + 1,  mk(0, 0, 0, 0, 0), "R8 uv beats start");
      push(cyc + 20, mk(0, 0, 0, 0, 0), "R8 start lost");
      uv_rst_i = 1'b1;
      start_i  = 1'b1;
      @(negedge clk);
      uv_rst_i = 1'b0;
      start_i  = 1'b0;
      drain();

      // reset during precharge
      do_start(s, "R2 run B2");
      wait_until(s + 10);
      push(cyc + 1, mk(0, 0, 0, 0, 0), "R8 clear in precharge");
      uv_rst_i = 1'b1;
      @(negedge clk);
      uv_rst_i = 1'b0;
      drain();

      run_full(1'b0, "R9");

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #1520000;
      if (!finished) begin
         finished = 1'b1;
         failures++;
         $display("FAIL watchdog cyc=%0d actual=hung expected=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule